// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block times one successive-approximation conversion from the bus clock. A modulus prescaler divides the bus clock by (P+1), where P is a 5-bit field. A fixed divide-by-2 follows it and produces a single-cycle converter clock-enable. Every phase of the conversion advances only on that enable. The phases are:

- a buffered sample phase of 2 enables;
- a final sample phase of 2, 4, 8 or 16 enables;
- one bit-decision step per result bit, 8 or 10 steps depending on the resolution bit.

The analog front end is outside the block. Its comparator reaches the block as a digital input, and the block builds the result word from it, most significant bit first. The same output word is the trial code for the comparator while a conversion runs, and it is the finished result once done pulses.

The prescaler, sample-time and resolution fields are captured on the start strobe and held until done. A start that arrives during a conversion abandons it and begins again from the buffered sample phase. The result word has no back-pressure. It stays on the output from done until the next start. Software that keeps its prescaler default of 1 gets a converter clock at a quarter of the bus clock.

Top module: `adc_seq_top`

## Requirements
- R1: While a conversion is running, cen_o is high for exactly one cycle in every 2*(P+1) bus cycles. Its first pulse is high in the cycle that follows the (2*(P+1)-1)-th rising edge after the edge that sampled start_i.
- R2: After reset, and whenever no conversion is running, cen_o, all phase outputs, bit_stb_o and done_o are 0, and result_o is 0 until the first conversion.
- R3: ph_buf_o is high for exactly 2 enables. ph_fin_o follows it for 2, 4, 8 or 16 enables when smp_i is 00, 01, 10 or 11. ph_conv_o comes last.
- R4: With res10_i=0 a conversion has 8 decision strobes. With res10_i=1 it has 10. bit_stb_o is high only together with cen_o during ph_conv_o, and bit_idx_o counts down from 7 or 9 to 0.
- R5: On entry to the decision phase, result_o holds only the top trial bit set. At the strobe with index i, bit i takes the value of cmp_i and bit i-1, if it exists, is set as the next trial bit. With a comparator that reports trial <= V, the result equals V.
- R6: done_o is high for one cycle, in the cycle after the edge that takes the last decision. That edge is 2*(P+1)*(2+L+N) edges after the start edge, where L is the final sample length and N the bit count. result_o is right-justified and its upper two bits are 0 in 8-bit mode.
- R7: Changes to presc_i, smp_i and res10_i after the start edge have no effect on the running conversion.
- R8: A start during a conversion aborts it: no done for it, ph_buf_o high after the edge, and the timing restarts as in R1.
- R9: At most one of ph_buf_o, ph_fin_o and ph_conv_o is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_n_i | input | 1 | active-low reset |
| start_i | input | 1 | start (or restart) strobe |
| presc_i | input | 5 | prescaler field P, divide factor P+1 |
| smp_i | input | 2 | final sample length select |
| res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit |
| cmp_i | input | 1 | comparator: 1 keeps the trial bit |
| cen_o | output | 1 | converter clock-enable pulse |
| ph_buf_o | output | 1 | buffered sample phase |
| ph_fin_o | output | 1 | final sample phase |
| ph_conv_o | output | 1 | bit decision phase |
| bit_stb_o | output | 1 | decision strobe |
| bit_idx_o | output | 4 | index of the bit being decided |
| done_o | output | 1 | conversion complete pulse |
| result_o | output | 10 | trial code while running, result after done |

## Verification
The bench counts falling edges from the cycle in which it raises start_i. Counted that way, the first cen_o pulse is due 2*(P+1) edges later, and each following pulse exactly 2*(P+1) edges after the one before it. done_o is due 1+2*(P+1)*(2+L+N) edges after start, and the bench compares the result word at that same sample. Every check samples outputs at the falling edge, half a cycle after the rising edge that moved them. The driver raises inputs just after a falling edge, so the counting has no ordering race at a clock edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_BUF, PH_FIN, PH_CONV} phase_e;
endpackage

// File: rtl/adc_clkgen.sv
// Modulus prescaler (div+1) followed by a divide-by-2; emits a one-cycle enable.
module adc_clkgen #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [PW-1:0] div_i,
  output logic          cen_o
);
  logic [PW-1:0] cnt_q;
  logic          half_q;
  logic          wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cen_o = run_i && !restart_i && half_q && wrap;
endmodule

// File: rtl/adc_phase_seq.sv
// Phase sequencer: buffered sample, final sample, bit decisions.
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int SMPW    = 2,
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8,
  localparam int CW     = 1 << SMPW,
  localparam int IW     = $clog2(HI_BITS)
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            start_i,
  input  logic            cen_i,
  input  logic [SMPW-1:0] smp_i,
  input  logic            res10_i,
  output phase_e          phase_o,
  output logic            arm_o,
  output logic            stb_o,
  output logic [IW-1:0]   idx_o,
  output logic            done_o
);
  localparam int SMAX   = (1 << SMPW) - 1;
  localparam int BUFLEN = 2;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] bi_q;
  logic          done_q;
  logic [CW-1:0] fin_last;

  assign fin_last = {CW{1'b1}} >> (SMAX - int'(smp_i));

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bi_q   <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      ph_q   <= PH_BUF;
      cnt_q  <= '0;
      bi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cen_i) begin
        unique case (ph_q)
          PH_BUF: begin
            if (cnt_q == CW'(BUFLEN - 1)) begin
              ph_q  <= PH_FIN;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_FIN: begin
            if (cnt_q == fin_last) begin
              ph_q  <= PH_CONV;
              cnt_q <= '0;
              bi_q  <= res10_i ? IW'(HI_BITS - 1) : IW'(LO_BITS - 1);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_CONV: begin
            if (bi_q == '0) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              bi_q <= bi_q - 1'b1;
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o = ph_q;
  assign arm_o   = cen_i && (ph_q == PH_FIN) && (cnt_q == fin_last);
  assign stb_o   = cen_i && (ph_q == PH_CONV);
  assign idx_o   = bi_q;
  assign done_o  = done_q;
endmodule

// File: rtl/adc_sar.sv
// Successive-approximation word: trial bit preset, keep/clear per comparator.
module adc_sar #(
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8,
  localparam int IW     = $clog2(HI_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               clr_i,
  input  logic               arm_i,
  input  logic               res10_i,
  input  logic               step_i,
  input  logic [IW-1:0]      idx_i,
  input  logic               cmp_i,
  output logic [HI_BITS-1:0] word_o
);
  logic [HI_BITS-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (clr_i) begin
      word_d = '0;
    end else if (arm_i) begin
      word_d = '0;
      word_d[res10_i ? HI_BITS - 1 : LO_BITS - 1] = 1'b1;
    end else if (step_i) begin
      word_d[idx_i] = cmp_i;
      if (idx_i != '0) word_d[idx_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) word_q <= '0;
    else          word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int PW       = 5,
  parameter int SMPW     = 2,
  parameter int HI_BITS  = 10,
  parameter int LO_BITS  = 8,
  localparam int IW      = $clog2(HI_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               start_i,
  input  logic [PW-1:0]      presc_i,
  input  logic [SMPW-1:0]    smp_i,
  input  logic               res10_i,
  input  logic               cmp_i,
  output logic               cen_o,
  output logic               ph_buf_o,
  output logic               ph_fin_o,
  output logic               ph_conv_o,
  output logic               bit_stb_o,
  output logic [IW-1:0]      bit_idx_o,
  output logic               done_o,
  output logic [HI_BITS-1:0] result_o
);
  logic [PW-1:0]   presc_q;
  logic [SMPW-1:0] smp_q;
  logic            res10_q;
  phase_e          phase;
  logic            cen, arm, stb, busy;
  logic [IW-1:0]   idx;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      presc_q <= PW'(1);
      smp_q   <= '0;
      res10_q <= 1'b0;
    end else if (start_i) begin
      presc_q <= presc_i;
      smp_q   <= smp_i;
      res10_q <= res10_i;
    end
  end

  assign busy = (phase != PH_IDLE);

  adc_clkgen #(.PW(PW)) u_clk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .run_i(busy), .restart_i(start_i),
    .div_i(presc_q), .cen_o(cen)
  );

  adc_phase_seq #(.SMPW(SMPW), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_seq (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(start_i), .cen_i(cen),
    .smp_i(smp_q), .res10_i(res10_q), .phase_o(phase), .arm_o(arm),
    .stb_o(stb), .idx_o(idx), .done_o(done_o)
  );

  adc_sar #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_sar (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(start_i), .arm_i(arm),
    .res10_i(res10_q), .step_i(stb), .idx_i(idx), .cmp_i(cmp_i),
    .word_o(result_o)
  );

  assign cen_o     = cen;
  assign ph_buf_o  = (phase == PH_BUF);
  assign ph_fin_o  = (phase == PH_FIN);
  assign ph_conv_o = (phase == PH_CONV);
  assign bit_stb_o = stb;
  assign bit_idx_o = idx;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cen,
  input logic ph_buf,
  input logic ph_fin,
  input logic ph_conv,
  input logic bit_stb,
  input logic done
);
  assert_phase_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_buf, ph_fin, ph_conv}));

  assert_cen_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cen |-> (ph_buf || ph_fin || ph_conv));

  assert_cen_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> !cen);

  assert_strobe_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (ph_conv && cen));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ph_conv) && !ph_conv));

  assert_restart_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph_buf && !done));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk(clk_i), .rst_n(rst_n_i), .start(start_i), .cen(cen_o),
  .ph_buf(ph_buf_o), .ph_fin(ph_fin_o), .ph_conv(ph_conv_o),
  .bit_stb(bit_stb_o), .done(done_o)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  typedef struct {
    int start_n;
    int p;
    int s;
    int nb;
    int expv;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] presc = 5'd1;
  logic [1:0] smp = 2'd0;
  logic       res10 = 1'b0;
  logic       cmp;
  logic [9:0] tgt = '0;
  logic       cen, ph_buf, ph_fin, ph_conv, bit_stb, done;
  logic [3:0] bit_idx;
  logic [9:0] result;

  int total = 0;
  int bad = 0;
  int ncnt = 0;
  item_t exp_q[$];
  int mon_last, mon_idx, mon_stb, mon_buf, mon_fin;

  always #2.5 clk = ~clk;

  assign cmp = (result <= tgt);

  adc_seq_top dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .presc_i(presc),
    .smp_i(smp), .res10_i(res10), .cmp_i(cmp), .cen_o(cen),
    .ph_buf_o(ph_buf), .ph_fin_o(ph_fin), .ph_conv_o(ph_conv),
    .bit_stb_o(bit_stb), .bit_idx_o(bit_idx), .done_o(done),
    .result_o(result)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    ncnt++;
    if (rst_n && exp_q.size() > 0) begin
      if (cen) begin
        check("R1 cen spacing", ncnt - mon_last, 2 * (exp_q[0].p + 1));
        mon_last = ncnt;
        if (ph_buf) mon_buf++;
        if (ph_fin) mon_fin++;
      end
      if (bit_stb) begin
        check("R4 bit index", int'(bit_idx), mon_idx);
        mon_idx--;
        mon_stb++;
      end
      if (done) begin
        item_t it;
        it = exp_q.pop_front();
        check("R5 R6 result", int'(result), it.expv);
        check("R6 done timing", ncnt - it.start_n,
              1 + 2 * (it.p + 1) * (2 + (2 << it.s) + it.nb));
        check("R4 strobe count", mon_stb, it.nb);
        check("R3 buffered length", mon_buf, 2);
        check("R3 final length", mon_fin, 2 << it.s);
      end
    end else if (rst_n && done) begin
      check("R8 unexpected done", 1, 0);
    end
  end

  task automatic begin_conv(input int p, input int s, input int r, input int v);
    item_t it;
    @(negedge clk); #1;
    presc = 5'(p); smp = 2'(s); res10 = r[0]; tgt = 10'(v);
    it.start_n = ncnt; it.p = p; it.s = s; it.nb = r ? 10 : 8; it.expv = v;
    mon_last = ncnt; mon_idx = it.nb - 1; mon_stb = 0; mon_buf = 0; mon_fin = 0;
    exp_q.push_back(it);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cen_seen;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset cen", int'(cen), 0);
    check("R2 reset phases", int'({ph_buf, ph_fin, ph_conv}), 0);
    check("R2 reset done", int'(done), 0);
    check("R2 reset result", int'(result), 0);
    #1 rst_n = 1'b1;
    cen_seen = 0;
    repeat (20) begin
      @(negedge clk);
      cen_seen += int'(cen) + int'(bit_stb) + int'(done);
    end
    check("R2 idle quiet", cen_seen, 0);

    begin_conv(0, 0, 0, 8'hA5);  wait_idle();
    begin_conv(1, 1, 1, 10'h2C3); wait_idle();
    begin_conv(31, 3, 1, 1023);  wait_idle();
    begin_conv(5, 2, 0, 0);      wait_idle();
    begin_conv(3, 1, 0, 255);    wait_idle();
    begin_conv(2, 0, 1, 10'h155); wait_idle();

    // R7: fields change after start are ignored
    begin_conv(2, 1, 0, 8'h3C);
    presc = 5'd9; smp = 2'd3; res10 = 1'b1;
    wait_idle();
    check("R6 R7 upper bits zero in 8-bit", int'(result[9:8]), 0);

    // R8: abort mid-conversion and restart
    begin_conv(4, 2, 1, 10'h0F0);
    repeat (60) @(negedge clk);
    void'(exp_q.pop_back());
    begin_conv(1, 0, 0, 8'h81);
    wait_idle();
    cen_seen = 0;
    repeat (20) begin
      @(negedge clk);
      cen_seen += int'(cen) + int'(done);
    end
    check("R2 R8 quiet after restart done", cen_seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule